// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned operands of `W` bits (at least 2, default 4) with a single one-bit full adder. The full adder is reused over `W` clock cycles, one bit position per cycle, least significant bit first. The augend is held in a right-shifting register. Each sum bit is shifted back into that register's top end, so after the last step the register holds the sum. The addend is held in a second right-shifting register that moves in step with the first and refills its top bit from an external serial line. One carry flip-flop carries the carry-out of each bit position into the next one.

A one-cycle start pulse does three things: it loads both operands in parallel, clears the carry and restarts the bit counter. The register pair then advances only on cycles where the shift enable is high. After the `W`-th enabled step the done flag rises and shifting stops. From then on the result and the final carry stay on the outputs until the next start. A start pulse seen while an addition is in flight abandons that addition and begins a new one.

Top module: `serial_acc_adder`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `sum_o` is 0, `cout_o` is 0 and `done_o` is 0.
- R2: On the cycle after a start pulse, `sum_o` equals the loaded `a_i` value and `done_o` is 0.
- R3: `done_o` rises exactly after the `W`-th clock edge at which `shift_en_i` was high following a start. It stays low before that edge.
- R4: While an addition is running, a cycle with `shift_en_i` low leaves `sum_o` unchanged.
- R5: When `done_o` is high, `{cout_o, sum_o}` equals the unsigned `a_i + b_i` captured at start, as a `W+1` bit value. `sum_o` holds bits `W-1:0` and `cout_o` holds bit `W`.
- R6: Once `done_o` is high and no start arrives, `done_o`, `sum_o` and `cout_o` stay unchanged even if `shift_en_i` is high.
- R7: `cout_o` reads 0 whenever `done_o` is low.
- R8: The value on `b_ser_i` during an addition has no effect on the result reported at done.
- R9: A start pulse during a running addition discards it: the carry is cleared and the new operands produce a correct result after `W` further enabled steps.
- R10: Each enabled step shifts `sum_o` right by one: the new bits `W-2:0` equal the previous bits `W-1:1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load both operands, clear carry, restart the step count |
| a_i | input | W | Augend, parallel load value |
| b_i | input | W | Addend, parallel load value |
| shift_en_i | input | 1 | Advances one bit position when high during a run |
| b_ser_i | input | 1 | Serial fill bit entering the top of the addend register |
| sum_o | output | W | Contents of the augend/sum register |
| cout_o | output | 1 | Final carry, valid while done is high, else 0 |
| done_o | output | 1 | High after W enabled steps, until the next start |

## Verification
Every pair of 4-bit operands is added. This covers carry chains that stop early, carries that ripple through every position, and sums that overflow into `cout_o`. Each pair runs with the shift enable either held high or toggled every cycle. This shows whether the step count and the carry depend only on enabled edges and not on elapsed cycles. The serial fill bit is randomised during some runs and forced to one in a directed run, so a design that lets fill bits reach the adder gives a wrong sum. A start pulse in the middle of an addition tests whether a stale carry or step count survives into the next result.

// File: rtl/serial_acc_pkg.sv
package serial_acc_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    typedef enum logic [1:0] {
        SA_IDLE = 2'd0,
        SA_RUN  = 2'd1,
        SA_DONE = 2'd2
    } sa_phase_e;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {ser_in, q[W-1:1]};
        end
    end
endmodule

// File: rtl/sa_carry_cell.sv
module sa_carry_cell
    import serial_acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry_q
);
    fa_out_t fa;

    always_comb begin
        fa      = full_add(a_bit, b_bit, carry_q);
        sum_bit = fa.sum;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            carry_q <= 1'b0;
        end else if (en) begin
            carry_q <= fa.carry;
        end
    end
endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
    import serial_acc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic shift_en,
    output logic step,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sa_phase_e      phase;
    logic [CW-1:0]  cnt;

    assign step = (phase == SA_RUN) && shift_en && !start;
    assign done = (phase == SA_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= SA_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= SA_RUN;
            cnt   <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                phase <= SA_DONE;
            end
        end
    end
endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         shift_en_i,
    input  logic         b_ser_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         done_o
);
    logic         step;
    logic         done;
    logic         sum_bit;
    logic         carry_q;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;

    sa_seq_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .shift_en (shift_en_i),
        .step     (step),
        .done     (done)
    );

    sa_shift_reg #(.W(W)) u_areg (
        .clk      (clk),
        .rst      (rst),
        .load     (start_i),
        .load_val (a_i),
        .shift    (step),
        .ser_in   (sum_bit),
        .q        (a_q)
    );

    sa_shift_reg #(.W(W)) u_breg (
        .clk      (clk),
        .rst      (rst),
        .load     (start_i),
        .load_val (b_i),
        .shift    (step),
        .ser_in   (b_ser_i),
        .q        (b_q)
    );

    sa_carry_cell u_carry (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_i),
        .en      (step),
        .a_bit   (a_q[0]),
        .b_bit   (b_q[0]),
        .sum_bit (sum_bit),
        .carry_q (carry_q)
    );

    assign sum_o  = a_q;
    assign cout_o = done & carry_q;
    assign done_o = done;
endmodule

// File: rtl/serial_acc_adder_chk.sv
module serial_acc_adder_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         shift_en_i,
    input logic [W-1:0] sum_o,
    input logic         cout_o,
    input logic         done_o
);
    localparam int CW = $clog2(W + 1);

    logic          active;
    logic [CW-1:0] seen;
    logic [W-1:0]  op_a;
    logic [W-1:0]  op_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            seen   <= '0;
            op_a   <= '0;
            op_b   <= '0;
        end else if (start_i) begin
            active <= 1'b1;
            seen   <= '0;
            op_a   <= a_i;
            op_b   <= b_i;
        end else if (active && shift_en_i && !done_o) begin
            seen <= seen + 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (sum_o == '0) && !done_o && !cout_o); // R1

    AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (sum_o == $past(a_i)) && !done_o); // R2

    AST_DONE_AFTER_W: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (seen == CW'(W))); // R3

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !shift_en_i) |=> $stable(sum_o)); // R4

    AST_RESULT: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ({cout_o, sum_o} == ({1'b0, op_a} + {1'b0, op_b}))); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o && $stable(sum_o) && $stable(cout_o)); // R6

    AST_COUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> !cout_o); // R7

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (active && shift_en_i && !start_i && !done_o) |=>
            (sum_o[W-2:0] == $past(sum_o[W-1:1]))); // R10
endmodule

bind serial_acc_adder serial_acc_adder_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .shift_en_i (shift_en_i),
    .sum_o      (sum_o),
    .cout_o     (cout_o),
    .done_o     (done_o)
);

// File: tb/serial_acc_adder_tb.sv
module serial_acc_adder_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         shift_en_i = 1'b0;
    logic         b_ser_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         cout_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    logic [W:0] exp_q[$];
    logic       done_q = 1'b0;

    always #2.5 clk = ~clk;

    serial_acc_adder #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .shift_en_i(shift_en_i), .b_ser_i(b_ser_i),
        .sum_o(sum_o), .cout_o(cout_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected result per rising done.
    always @(negedge clk) begin
        if (!rst && done_o && !done_q) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected done", {cout_o, sum_o}, -1);
            end else begin
                logic [W:0] e;
                e = exp_q.pop_front();
                check({cout_o, sum_o} == e, "R5 R8 result", {cout_o, sum_o}, e);
            end
        end
        done_q = done_o;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit gap, input bit ones);
        logic [W-1:0] prev;
        int n;
        bit ph;
        logic [W:0] e;
        e = {1'b0, a} + {1'b0, b};
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b1; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0; a_i = ~a; b_i = ~b;
        check(sum_o == a, "R2 load", sum_o, a);
        check(!done_o, "R2 done low", done_o, 0);
        n = 0;
        ph = 1'b0;
        while (n < W) begin
            shift_en_i = gap ? ph : 1'b1;
            ph = ~ph;
            b_ser_i = ones ? 1'b1 : 1'($urandom);
            prev = sum_o;
            @(negedge clk);
            if (shift_en_i) begin
                n++;
            end else begin
                check(sum_o == prev, "R4 pause", sum_o, prev);
            end
            if (n < W) begin
                check(!done_o, "R3 early done", done_o, 0);
                check(!cout_o, "R7 cout quiet", cout_o, 0);
            end
        end
        shift_en_i = 1'b0;
        check(done_o, "R3 done after W", done_o, 1);
        shift_en_i = 1'b1;
        repeat (2) @(negedge clk);
        shift_en_i = 1'b0;
        check(done_o && {cout_o, sum_o} == e, "R6 hold", {cout_o, sum_o}, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sum_o == '0 && !done_o && !cout_o, "R1 in reset", {done_o, cout_o, sum_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(sum_o == '0 && !done_o && !cout_o, "R1 after reset", {done_o, cout_o, sum_o}, 0);

        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                do_add(W'(a), W'(b), ((a + b) % 3) == 0, 1'b0);
            end
        end

        // R8: serial fill forced high must not disturb the result
        do_add(4'd9, 4'd7, 1'b0, 1'b1);
        do_add(4'd0, 4'd0, 1'b1, 1'b1);

        // R9: restart in the middle of an addition
        @(negedge clk);
        start_i = 1'b1; a_i = 4'd15; b_i = 4'd15;
        @(negedge clk);
        start_i = 1'b0; shift_en_i = 1'b1;
        repeat (2) @(negedge clk);
        shift_en_i = 1'b0;
        check(!done_o, "R9 aborted run not done", done_o, 0);
        do_add(4'd3, 4'd4, 1'b0, 1'b0);
        check({cout_o, sum_o} == 5'd7, "R9 restart result", {cout_o, sum_o}, 7);

        // R10: one enabled step moves the register right by one
        @(negedge clk);
        start_i = 1'b1; a_i = 4'b1010; b_i = 4'b0000;
        @(negedge clk);
        start_i = 1'b0; shift_en_i = 1'b1; b_ser_i = 1'b0;
        @(negedge clk);
        shift_en_i = 1'b0;
        check(sum_o[W-2:0] == 3'b101, "R10 shift right", sum_o[W-2:0], 5);
        exp_q.push_back(5'd10);
        shift_en_i = 1'b1;
        repeat (W) @(negedge clk);
        shift_en_i = 1'b0;
        @(negedge clk);

        check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule